// File: doc/BRIEF.md
# Block Cipher Register Front End

This block is the software-visible face of a block-cipher engine that accepts 128-bit and 256-bit keys. A simple chip-select bus (select, write enable, 8-bit word address, 32-bit write and read data) reaches a fixed word-addressed map. The map holds three identification words, a control word, a status word, a configuration word, eight key words, four data-block words and four result words. The cipher datapath is not part of the block. It sits behind a port-level interface: command pulses, direction and key-length selects, the assembled key and block vectors, and the engine's ready, result-valid and result inputs.

Software loads the key and the configuration, then writes the control word with the init bit set. That write becomes a one-cycle init pulse toward the engine. Software then loads a data block, writes the next bit, polls status until ready is set, and reads the four result words. Multi-word quantities are arranged most-significant word first: the lowest address of a group supplies the top 32 bits. A 128-bit key uses the first four key words. Writes to read-only locations and any access to an unmapped address produce a one-cycle error pulse and change nothing. Reads take no wait states, and read data is combinational from the address.

Top module: `cipher_regif`

## Requirements
- R1: After reset the configuration, key and block registers are zero, so `core_key_o`, `core_block_o`, `core_encdec_o` and `core_keylen_o` are all zero, and `core_init_o`, `core_next_o` and `err_o` are low.
- R2: Reads of address 0x00, 0x01 and 0x02 return the parameter words NAME_HI, NAME_LO and VERSION.
- R3: A write to address 0x08 with bit 0 set drives `core_init_o` high for exactly the one cycle after the write edge. Bit 1 does the same for `core_next_o`, and both may fire together. A read of 0x08 returns zero.
- R4: A read of 0x09 returns the engine ready input in bit 0 and the result-valid input in bit 1, with all other bits zero.
- R5: Address 0x0a holds two bits. Bit 0 drives `core_encdec_o` (1 = encipher) and bit 1 drives `core_keylen_o` (1 = 256-bit). A read returns those two bits with the upper bits zero.
- R6: Key words at 0x10..0x17 are writable and readable. The word at 0x10+i drives `core_key_o[255-32*i -: 32]`.
- R7: Block words at 0x20..0x23 are writable and readable. The word at 0x20+i drives `core_block_o[127-32*i -: 32]`.
- R8: Reads of 0x30+i (i = 0..3) return `core_result_i[127-32*i -: 32]`.
- R9: `err_o` is high for the one cycle after an access edge when that access was a write to 0x00-0x02, 0x09 or 0x30-0x33, or any access to an unmapped address. Unmapped reads return zero, and such writes change no register.
- R10: Legal accesses never raise `err_o`, and stored registers keep their values until they are rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Access select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| err_o | output | 1 | Illegal-access pulse |
| core_init_o | output | 1 | Key-expansion start pulse |
| core_next_o | output | 1 | Block-processing start pulse |
| core_encdec_o | output | 1 | Direction select, 1 = encipher |
| core_keylen_o | output | 1 | Key length select, 1 = 256-bit |
| core_key_o | output | 256 | Assembled key, MSB word from 0x10 |
| core_block_o | output | 128 | Assembled data block, MSB word from 0x20 |
| core_ready_i | input | 1 | Engine ready |
| core_valid_i | input | 1 | Engine result valid |
| core_result_i | input | 128 | Engine result |

## Verification
The bench checks word ordering on the key, block and result groups by writing a distinct pattern to each word. A design that swapped the ordering would put the wrong 32 bits at the top of the key or return result words reversed. Command bits are checked in single, paired and read-back forms. A design whose command bits failed to self-clear would hold init or next high past one cycle, or return ones on a control read. Writes to identification, status and result locations, and accesses just past the end of each group (0x18, 0x24, 0x34, 0x0b), must raise the error pulse and leave stored state untouched. A loose decode would instead alias those accesses onto a real register and corrupt it silently.

// File: rtl/cipher_regif_pkg.sv
package cipher_regif_pkg;
  localparam logic [7:0] A_NAME_HI = 8'h00;
  localparam logic [7:0] A_NAME_LO = 8'h01;
  localparam logic [7:0] A_VER     = 8'h02;
  localparam logic [7:0] A_CTRL    = 8'h08;
  localparam logic [7:0] A_STAT    = 8'h09;
  localparam logic [7:0] A_CFG     = 8'h0a;
  localparam logic [3:0] G_KEY     = 4'h1;
  localparam logic [3:0] G_BLK     = 4'h2;
  localparam logic [3:0] G_RES     = 4'h3;

  typedef enum logic [3:0] {
    RG_NONE, RG_NAME_HI, RG_NAME_LO, RG_VER, RG_CTRL,
    RG_STAT, RG_CFG, RG_KEY, RG_BLK, RG_RES
  } region_e;

  function automatic logic is_writable(region_e r);
    return (r == RG_CTRL) || (r == RG_CFG) || (r == RG_KEY) || (r == RG_BLK);
  endfunction
endpackage

// File: rtl/regif_decode.sv
module regif_decode
  import cipher_regif_pkg::*;
(
  input  logic [7:0] addr_i,
  output region_e    region_o,
  output logic [2:0] idx_o
);
  always_comb begin
    idx_o    = addr_i[2:0];
    region_o = RG_NONE;
    case (addr_i)
      A_NAME_HI: region_o = RG_NAME_HI;
      A_NAME_LO: region_o = RG_NAME_LO;
      A_VER:     region_o = RG_VER;
      A_CTRL:    region_o = RG_CTRL;
      A_STAT:    region_o = RG_STAT;
      A_CFG:     region_o = RG_CFG;
      default: begin
        if (addr_i[7:4] == G_KEY && !addr_i[3])                  region_o = RG_KEY;
        else if (addr_i[7:4] == G_BLK && addr_i[3:2] == 2'b00)   region_o = RG_BLK;
        else if (addr_i[7:4] == G_RES && addr_i[3:2] == 2'b00)   region_o = RG_RES;
      end
    endcase
  end
endmodule

// File: rtl/regif_wordbank.sv
module regif_wordbank #(
  parameter int NWORDS = 4,
  parameter int W      = 32,
  parameter int IDX_W  = $clog2(NWORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [W-1:0]        wdata_i,
  output logic [NWORDS*W-1:0] flat_o,
  output logic [W-1:0]        rword_o
);
  logic [W-1:0] words [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (wr_i && idx_i == IDX_W'(g))  q <= wdata_i;
    end
    assign words[g] = q;
    // lowest index lands in the most significant slot
    assign flat_o[(NWORDS-1-g)*W +: W] = q;
  end

  assign rword_o = words[idx_i];
endmodule

// File: rtl/regif_rdmux.sv
module regif_rdmux
  import cipher_regif_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          RES_WORDS = 4,
  parameter int          RIDX_W    = $clog2(RES_WORDS),
  parameter logic [31:0] NAME_HI   = 32'h0,
  parameter logic [31:0] NAME_LO   = 32'h0,
  parameter logic [31:0] VERSION   = 32'h0
) (
  input  region_e                       region_i,
  input  logic [RIDX_W-1:0]             ridx_i,
  input  logic                          ready_i,
  input  logic                          valid_i,
  input  logic [1:0]                    cfg_i,
  input  logic [DATA_W-1:0]             key_word_i,
  input  logic [DATA_W-1:0]             blk_word_i,
  input  logic [RES_WORDS*DATA_W-1:0]   result_i,
  output logic [DATA_W-1:0]             rdata_o
);
  logic [DATA_W-1:0] res_word;

  always_comb begin
    res_word = '0;
    for (int k = 0; k < RES_WORDS; k++)
      if (ridx_i == RIDX_W'(k)) res_word = result_i[(RES_WORDS-1-k)*DATA_W +: DATA_W];
  end

  always_comb begin
    rdata_o = '0;
    case (region_i)
      RG_NAME_HI: rdata_o = DATA_W'(NAME_HI);
      RG_NAME_LO: rdata_o = DATA_W'(NAME_LO);
      RG_VER:     rdata_o = DATA_W'(VERSION);
      RG_STAT:    rdata_o = DATA_W'({valid_i, ready_i});
      RG_CFG:     rdata_o = DATA_W'(cfg_i);
      RG_KEY:     rdata_o = key_word_i;
      RG_BLK:     rdata_o = blk_word_i;
      RG_RES:     rdata_o = res_word;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cipher_regif.sv
module cipher_regif
  import cipher_regif_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          KEY_WORDS = 8,
  parameter int          BLK_WORDS = 4,
  parameter logic [31:0] NAME_HI   = 32'h6369_7068,
  parameter logic [31:0] NAME_LO   = 32'h7267_6966,
  parameter logic [31:0] VERSION   = 32'h0001_0003,
  localparam int         KEY_W     = KEY_WORDS * DATA_W,
  localparam int         BLK_W     = BLK_WORDS * DATA_W,
  localparam int         KIDX_W    = $clog2(KEY_WORDS),
  localparam int         BIDX_W    = $clog2(BLK_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              core_init_o,
  output logic              core_next_o,
  output logic              core_encdec_o,
  output logic              core_keylen_o,
  output logic [KEY_W-1:0]  core_key_o,
  output logic [BLK_W-1:0]  core_block_o,
  input  logic              core_ready_i,
  input  logic              core_valid_i,
  input  logic [BLK_W-1:0]  core_result_i
);
  region_e           region;
  logic [2:0]        idx;
  logic              wr, illegal;
  logic              err_q, init_q, next_q;
  logic [1:0]        cfg_q;
  logic [DATA_W-1:0] key_word, blk_word;

  regif_decode u_decode (.addr_i(addr_i), .region_o(region), .idx_o(idx));

  assign wr      = cs_i && we_i;
  assign illegal = cs_i && ((region == RG_NONE) || (we_i && !is_writable(region)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      init_q <= 1'b0;
      next_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      err_q  <= illegal;
      // command bits live one cycle only
      init_q <= wr && (region == RG_CTRL) && wdata_i[0];
      next_q <= wr && (region == RG_CTRL) && wdata_i[1];
      if (wr && region == RG_CFG) cfg_q <= wdata_i[1:0];
    end
  end

  regif_wordbank #(.NWORDS(KEY_WORDS), .W(DATA_W)) u_key (
    .clk_i, .rst_ni,
    .wr_i(wr && region == RG_KEY), .idx_i(idx[KIDX_W-1:0]), .wdata_i(wdata_i),
    .flat_o(core_key_o), .rword_o(key_word)
  );

  regif_wordbank #(.NWORDS(BLK_WORDS), .W(DATA_W)) u_blk (
    .clk_i, .rst_ni,
    .wr_i(wr && region == RG_BLK), .idx_i(idx[BIDX_W-1:0]), .wdata_i(wdata_i),
    .flat_o(core_block_o), .rword_o(blk_word)
  );

  regif_rdmux #(
    .DATA_W(DATA_W), .RES_WORDS(BLK_WORDS),
    .NAME_HI(NAME_HI), .NAME_LO(NAME_LO), .VERSION(VERSION)
  ) u_rdmux (
    .region_i(region), .ridx_i(idx[BIDX_W-1:0]),
    .ready_i(core_ready_i), .valid_i(core_valid_i), .cfg_i(cfg_q),
    .key_word_i(key_word), .blk_word_i(blk_word), .result_i(core_result_i),
    .rdata_o(rdata_o)
  );

  assign err_o         = err_q;
  assign core_init_o   = init_q;
  assign core_next_o   = next_q;
  assign core_encdec_o = cfg_q[0];
  assign core_keylen_o = cfg_q[1];
endmodule

// File: rtl/cipher_regif_chk.sv
module cipher_regif_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cs_i,
  input logic         we_i,
  input logic [7:0]   addr_i,
  input logic [1:0]   wbit_i,
  input logic         err_o,
  input logic         core_init_o,
  input logic         core_next_o,
  input logic         core_encdec_o,
  input logic         core_keylen_o,
  input logic [255:0] core_key_o
);
  // R3: init pulse only follows a control write carrying bit 0
  a_r3_init_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_init_o |-> $past(cs_i && we_i && addr_i == 8'h08 && wbit_i[0]));

  // R3: next pulse only follows a control write carrying bit 1
  a_r3_next_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_next_o |-> $past(cs_i && we_i && addr_i == 8'h08 && wbit_i[1]));

  // R3: a pulse never survives an idle cycle
  a_r3_init_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_init_o && !cs_i) |=> !core_init_o);

  // R9: error needs an access in the prior cycle
  a_r9_err_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(cs_i));

  // R10: config holds unless written at its own address
  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && we_i && addr_i == 8'h0a) |=> $stable({core_encdec_o, core_keylen_o}));

  // R10: key holds unless a key word is written
  a_r10_key_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && we_i && addr_i[7:3] == 5'b00010) |=> $stable(core_key_o));
endmodule

bind cipher_regif cipher_regif_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
  .wbit_i(wdata_i[1:0]), .err_o(err_o), .core_init_o(core_init_o),
  .core_next_o(core_next_o), .core_encdec_o(core_encdec_o),
  .core_keylen_o(core_keylen_o), .core_key_o(core_key_o)
);

// File: tb/cipher_regif_bench.sv
`timescale 1ns/1ps
module cipher_regif_bench;
  localparam logic [31:0] NAME_HI = 32'h6369_7068;
  localparam logic [31:0] NAME_LO = 32'h7267_6966;
  localparam logic [31:0] VERSION = 32'h0001_0003;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs = 1'b0, we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         err, init_p, next_p, encdec, keylen;
  logic [255:0] key;
  logic [127:0] blk;
  logic         ready = 1'b0, valid = 1'b0;
  logic [127:0] result = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cipher_regif u_cipher_regif (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .core_init_o(init_p), .core_next_o(next_p),
    .core_encdec_o(encdec), .core_keylen_o(keylen),
    .core_key_o(key), .core_block_o(blk),
    .core_ready_i(ready), .core_valid_i(valid), .core_result_i(result)
  );

  // scoreboard queues, one entry per access
  bit          q_rd  [$];
  logic [31:0] q_rdv [$];
  logic [2:0]  q_flg [$];   // {err, init, next}
  string       q_tag [$];

  function automatic void chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] exp_rd, input logic [2:0] flg, input string tag);
    q_rd.push_back(!w); q_rdv.push_back(exp_rd); q_flg.push_back(flg); q_tag.push_back(tag);
    @(posedge clk); #2;
    cs = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk); #2;
    cs = 1'b0; we = 1'b0;
  endtask

  // monitor: reads checked in the access cycle, pulses one cycle later
  logic [2:0] cur_flg;
  string      cur_tag;
  bit         have_cur = 0;
  always @(negedge clk) begin
    if (have_cur) begin
      chk({err, init_p, next_p} == cur_flg, cur_tag, {err, init_p, next_p}, cur_flg);
      have_cur = 0;
    end
    if (cs && q_rd.size() > 0) begin
      bit rd_now;
      logic [31:0] exp_v;
      rd_now  = q_rd.pop_front();
      exp_v   = q_rdv.pop_front();
      cur_flg = q_flg.pop_front();
      cur_tag = q_tag.pop_front();
      if (rd_now) chk(rdata == exp_v, {cur_tag, " rdata"}, rdata, exp_v);
      have_cur = 1;
    end
  end

  logic [255:0] kpat = 256'h603d_eb10_15ca_71be_2b73_aef0_857d_7781_1f35_2c07_3b61_08d7_2d98_10a3_0914_dff4;
  logic [127:0] bpat = 128'h6bc1_bee2_2e40_9f96_e93d_7e11_7393_172a;
  logic [127:0] rpat = 128'h3ad7_7bb4_0d7a_3660_a89e_caf3_2466_ef97;

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(key == '0, "R1 key", key, 0);
    chk(blk == '0, "R1 block", blk, 0);
    chk({encdec, keylen} == 2'b00, "R1 cfg", {encdec, keylen}, 0);
    chk({err, init_p, next_p} == 3'b000, "R1 pulses", {err, init_p, next_p}, 0);

    // R2 identification words
    access(0, 8'h00, 0, NAME_HI, 3'b000, "R2 name_hi");
    access(0, 8'h01, 0, NAME_LO, 3'b000, "R2 name_lo");
    access(0, 8'h02, 0, VERSION, 3'b000, "R2 version");

    // R6 key words, MSB first
    for (int i = 0; i < 8; i++)
      access(1, 8'h10 + 8'(i), kpat[255-32*i -: 32], 0, 3'b000, "R6 key write");
    @(negedge clk);
    chk(key == kpat, "R6 key bus", key, kpat);
    access(0, 8'h13, 0, kpat[159:128], 3'b000, "R6 key readback");

    // R7 block words
    for (int i = 0; i < 4; i++)
      access(1, 8'h20 + 8'(i), bpat[127-32*i -: 32], 0, 3'b000, "R7 block write");
    @(negedge clk);
    chk(blk == bpat, "R7 block bus", blk, bpat);
    access(0, 8'h21, 0, bpat[95:64], 3'b000, "R7 block readback");

    // R5 config
    access(1, 8'h0a, 32'hffff_fffe, 0, 3'b000, "R5 cfg write keylen");
    @(negedge clk);
    chk({keylen, encdec} == 2'b10, "R5 cfg bits", {keylen, encdec}, 2'b10);
    access(0, 8'h0a, 0, 32'h2, 3'b000, "R5 cfg read");
    access(1, 8'h0a, 32'h1, 0, 3'b000, "R5 cfg write enc");
    access(0, 8'h0a, 0, 32'h1, 3'b000, "R5 cfg read enc");

    // R3 commands
    access(1, 8'h08, 32'h1, 0, 3'b010, "R3 init");
    access(1, 8'h08, 32'h2, 0, 3'b001, "R3 next");
    access(1, 8'h08, 32'h3, 0, 3'b011, "R3 both");
    access(0, 8'h08, 0, 32'h0, 3'b000, "R3 ctrl reads zero");

    // R4 status
    ready = 1'b1; valid = 1'b0;
    access(0, 8'h09, 0, 32'h1, 3'b000, "R4 ready");
    ready = 1'b0; valid = 1'b1;
    access(0, 8'h09, 0, 32'h2, 3'b000, "R4 valid");

    // R8 result words
    result = rpat;
    for (int i = 0; i < 4; i++)
      access(0, 8'h30 + 8'(i), 0, rpat[127-32*i -: 32], 3'b000, "R8 result");

    // R9 illegal accesses
    access(1, 8'h00, 32'hdead_beef, 0, 3'b100, "R9 write name");
    access(0, 8'h00, 0, NAME_HI, 3'b000, "R9 name unchanged");
    access(1, 8'h09, 32'h3, 0, 3'b100, "R9 write status");
    access(1, 8'h31, 32'h1234, 0, 3'b100, "R9 write result");
    access(0, 8'h05, 0, 32'h0, 3'b100, "R9 unmapped read");
    access(0, 8'h0b, 0, 32'h0, 3'b100, "R9 read past cfg");
    access(1, 8'h18, 32'hffff_ffff, 0, 3'b100, "R9 write past key");
    access(1, 8'h24, 32'hffff_ffff, 0, 3'b100, "R9 write past block");
    access(0, 8'h34, 0, 32'h0, 3'b100, "R9 read past result");

    // R10 retention
    @(negedge clk); @(negedge clk);
    chk(key == kpat, "R10 key kept", key, kpat);
    chk(blk == bpat, "R10 block kept", blk, bpat);
    chk({keylen, encdec} == 2'b01, "R10 cfg kept", {keylen, encdec}, 2'b01);
    access(0, 8'h17, 0, kpat[31:0], 3'b000, "R10 key word kept");
    @(negedge clk); @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule